// File: doc/BRIEF.md
# Parallel Pseudorandom Test Word Generator

This block produces pseudorandom test data for checking a receiver's capture of a data converter's output stream. It contains two maximal-length linear feedback shift registers: a short 9-stage register and a long 23-stage register. Each enabled clock packs the next 12 serial bits of the selected sequence into one parallel word. The earliest bit goes in the most significant position, so a downstream serializer that sends MSB first rebuilds the original serial stream.

All 12 serial steps are unrolled in combinational logic, so the generator keeps up with one word per clock. A restart strobe, or a change of the sequence select, reseeds both registers to all ones. The next enabled word is then the first word of the sequence again. The word is registered and holds its value while the enable is low.

Top module: `pn_word_gen`

## Requirements
- R1: A synchronous reset, held high for at least one rising edge, clears `word_o` to 0x000 and seeds both registers to all ones. The first enabled edge after reset therefore outputs the first word of the selected sequence.
- R2: With `sel_long` = 0, the serial bits follow b(m) = b(m-9) xor b(m-5) (polynomial x^9 + x^5 + 1) from an all-ones seed. The first four words are 0xFF8, 0x3DF, 0x173 and 0x209. With the MSB inverted for twos-complement reading, these are 0x7F8, 0xBDF, 0x973 and 0xA09.
- R3: With `sel_long` = 1, the serial bits follow b(m) = b(m-23) xor b(m-18) (polynomial x^23 + x^18 + 1) from an all-ones seed. The bits are taken straight from the register, which is the complement of the standard's inverted long pattern. The first four words are 0xFFF, 0xFFE, 0x000 and 0x07C.
- R4: Each enabled rising edge consumes exactly 12 serial bits. The earliest bit goes to bit 11 and the latest to bit 0, and the new word is visible on `word_o` right after that edge.
- R5: While `en` is low, `word_o` keeps its value and neither sequence advances. The next enabled word continues the stream where it stopped.
- R6: `restart` high at a rising edge reseeds both registers. If `en` is also high at that edge, the word produced there is the first word of the selected sequence. Otherwise the next enabled edge produces it.
- R7: A change of `sel_long` relative to its value at the previous edge reseeds both registers in the same way as R6, both with and without `en`.
- R8: The short-sequence word stream repeats with a period of 511 words, so word 512 after a reseed equals word 1 (0xFF8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Word enable; one word is produced per enabled edge |
| sel_long | input | 1 | Sequence select: 0 = 9-stage, 1 = 23-stage |
| restart | input | 1 | Reseed strobe |
| word_o | output | 12 | Registered parallel test word, earliest bit in bit 11 |

## Verification
Two functions can land on the same edge: reseeding (from `restart` or from a change of `sel_long`) and producing a word. The bench asserts `restart` together with `en`, and separately flips `sel_long` while `en` is high. In both cases it expects the first word of the sequence on that very edge, not one edge later, and then the second word on the following edge. The same reseeds are repeated with `en` low, where the bench expects `word_o` to hold and the first word to appear on the next enabled edge.

// File: rtl/pn_pkg.sv
package pn_pkg;

    // Width of one parallel output word (serial bits per enabled clock).
    localparam int PN_WORD_W = 12;

    typedef logic [PN_WORD_W-1:0] pn_word_t;

    typedef enum logic {
        SEQ_SHORT = 1'b0,
        SEQ_LONG  = 1'b1
    } pn_seq_e;

    // Per-cycle control decided from the strobes.
    typedef struct packed {
        logic    reseed;   // reload the all-ones seed
        logic    advance;  // produce a word and step the selected register
        pn_seq_e seq;      // sequence in use this cycle
    } pn_ctl_t;

    // First word of a Fibonacci register of length len, taps len and tap,
    // seeded with all ones.  Used as a constant by the assertions.
    function automatic pn_word_t pn_first_word(input int len, input int tap);
        logic [31:0] r;
        pn_word_t    w;
        logic        fb;
        r = '0;
        w = '0;
        for (int i = 0; i < 32; i++) begin
            if (i < len) r[i] = 1'b1;
        end
        for (int k = 0; k < PN_WORD_W; k++) begin
            w[PN_WORD_W-1-k] = r[len-1];
            fb = r[len-1] ^ r[tap-1];
            r  = {r[30:0], fb};
        end
        return w;
    endfunction

endpackage

// File: rtl/pn_ctrl.sv
module pn_ctrl
    import pn_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    restart,
    input  logic    sel_long,
    output pn_ctl_t ctl
);

    pn_seq_e sel_now;
    pn_seq_e sel_q;

    assign sel_now = sel_long ? SEQ_LONG : SEQ_SHORT;

    // Remember the select from the previous edge to spot a switch.
    always_ff @(posedge clk) begin
        if (rst) sel_q <= sel_now;
        else     sel_q <= sel_now;
    end

    always_comb begin
        ctl.seq     = sel_now;
        ctl.advance = en;
        ctl.reseed  = restart | (sel_now != sel_q);
    end

endmodule

// File: rtl/pn_lfsr_core.sv
module pn_lfsr_core
    import pn_pkg::*;
#(
    parameter int LEN = 9,
    parameter int TAP = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     reseed,
    input  logic     advance,
    output pn_word_t word
);

    localparam logic [LEN-1:0] SEED = {LEN{1'b1}};

    logic [LEN-1:0] state_q;
    logic [LEN-1:0] chain [PN_WORD_W+1];

    // A reseed on the same edge starts the word from the seed.
    assign chain[0] = reseed ? SEED : state_q;

    // Twelve serial steps unrolled; stage LEN (bit LEN-1) is the output.
    for (genvar k = 0; k < PN_WORD_W; k++) begin : g_step
        assign word[PN_WORD_W-1-k] = chain[k][LEN-1];
        assign chain[k+1] = {chain[k][LEN-2:0], chain[k][LEN-1] ^ chain[k][TAP-1]};
    end

    always_ff @(posedge clk) begin
        if (rst)          state_q <= SEED;
        else if (advance) state_q <= chain[PN_WORD_W];
        else if (reseed)  state_q <= SEED;
    end

    // R2 / R3: a maximal-length register never locks up at all zeros.
    p_state_live_r2: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

endmodule

// File: rtl/pn_word_gen.sv
module pn_word_gen
    import pn_pkg::*;
#(
    parameter int SHORT_LEN = 9,
    parameter int SHORT_TAP = 5,
    parameter int LONG_LEN  = 23,
    parameter int LONG_TAP  = 18
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 sel_long,
    input  logic                 restart,
    output logic [PN_WORD_W-1:0] word_o
);

    localparam pn_word_t FIRST_SHORT = pn_first_word(SHORT_LEN, SHORT_TAP);
    localparam pn_word_t FIRST_LONG  = pn_first_word(LONG_LEN, LONG_TAP);

    pn_ctl_t  ctl;
    pn_word_t word_s;
    pn_word_t word_l;
    logic     adv_s;
    logic     adv_l;

    pn_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .restart  (restart),
        .sel_long (sel_long),
        .ctl      (ctl)
    );

    // Only the selected register steps; both take a reseed.
    assign adv_s = ctl.advance && (ctl.seq == SEQ_SHORT);
    assign adv_l = ctl.advance && (ctl.seq == SEQ_LONG);

    pn_lfsr_core #(.LEN(SHORT_LEN), .TAP(SHORT_TAP)) u_short (
        .clk     (clk),
        .rst     (rst),
        .reseed  (ctl.reseed),
        .advance (adv_s),
        .word    (word_s)
    );

    pn_lfsr_core #(.LEN(LONG_LEN), .TAP(LONG_TAP)) u_long (
        .clk     (clk),
        .rst     (rst),
        .reseed  (ctl.reseed),
        .advance (adv_l),
        .word    (word_l)
    );

    always_ff @(posedge clk) begin
        if (rst)              word_o <= '0;
        else if (ctl.advance) word_o <= (ctl.seq == SEQ_LONG) ? word_l : word_s;
    end

    // R5: no enable, no change on the output.
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(word_o));

    // R6: restart together with enable emits the first word at once.
    p_restart_first_r6: assert property (@(posedge clk) disable iff (rst)
        (restart && en) |=>
            word_o == ($past(sel_long) ? FIRST_LONG : FIRST_SHORT));

    // R7: an enabled edge that sees a new select emits that sequence's first word.
    p_switch_first_r7: assert property (@(posedge clk) disable iff (rst)
        (en && (sel_long != $past(sel_long))) |=>
            word_o == ($past(sel_long) ? FIRST_LONG : FIRST_SHORT));

endmodule

// File: tb/pn_word_gen_bench.sv
module pn_word_gen_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [11:0] word;
        string       tag;
        int          due;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        sel_long = 1'b0;
    logic        restart = 1'b0;
    logic [11:0] word_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    exp_item_t q[$];

    // Reference: f[0] is the next serial bit, f[k] the bit k steps later.
    logic [8:0]  ref_s;
    logic [22:0] ref_l;
    logic [11:0] exp_out;
    logic        prev_sel;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pn_word_gen u_pn_word_gen (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .sel_long (sel_long),
        .restart  (restart),
        .word_o   (word_o)
    );

    function automatic logic [11:0] ref_word(input logic s);
        logic [11:0] w;
        logic        nb;
        w = '0;
        for (int k = 0; k < 12; k++) begin
            if (s) begin
                w[11-k] = ref_l[0];
                nb = ref_l[0] ^ ref_l[5];
                ref_l = {nb, ref_l[22:1]};
            end else begin
                w[11-k] = ref_s[0];
                nb = ref_s[0] ^ ref_s[4];
                ref_s = {nb, ref_s[8:1]};
            end
        end
        return w;
    endfunction

    task automatic reseed_ref();
        ref_s = '1;
        ref_l = '1;
    endtask

    // Driver: one cycle of stimulus, called at a falling edge.
    task automatic drive(input logic e, input logic s, input logic r, input string tag);
        exp_item_t it;
        en = e;
        sel_long = s;
        restart = r;
        if (r || (s != prev_sel)) reseed_ref();
        if (e) exp_out = ref_word(s);
        prev_sel = s;
        it.word = exp_out;
        it.tag = tag;
        it.due = cyc + 1;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic check_now(input logic [11:0] exp, input string tag);
        total++;
        if (word_o !== exp) begin
            bad++;
            $display("FAIL %s: word_o=%h expected=%h", tag, word_o, exp);
        end
    endtask

    // Monitor: pops items whose edge has passed and compares them.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_item_t it;
            it = q.pop_front();
            total++;
            if (word_o !== it.word) begin
                bad++;
                $display("FAIL %s: word_o=%h expected=%h", it.tag, word_o, it.word);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: word_o=%h expected=finish", word_o);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        exp_out = '0;
        prev_sel = 1'b0;
        reseed_ref();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_now(12'h000, "R1 reset value");

        // R1 / R2 / R4: first short words, MSB first
        drive(1, 0, 0, "R2 word1");
        check_now(12'hFF8, "R2 first word 0xFF8");
        drive(1, 0, 0, "R2 word2");
        check_now(12'h3DF, "R2 second word 0x3DF");
        drive(1, 0, 0, "R4 word3");
        check_now(12'h173, "R4 third word 0x173");
        drive(1, 0, 0, "R2 word4");
        check_now(12'h209, "R2 fourth word 0x209");
        for (int i = 0; i < 40; i++) drive(1, 0, 0, "R4 short stream");

        // R5: idle holds, then the stream continues
        for (int i = 0; i < 5; i++) drive(0, 0, 0, "R5 idle hold");
        for (int i = 0; i < 10; i++) drive(1, 0, 0, "R5 resume");
        for (int i = 0; i < 6; i++) drive(i[0], 0, 0, "R5 gapped enable");

        // R7: switch to long while enabled
        drive(1, 1, 0, "R7 switch enabled");
        check_now(12'hFFF, "R3 first long word 0xFFF");
        drive(1, 1, 0, "R3 word2");
        check_now(12'hFFE, "R3 second long word 0xFFE");
        drive(1, 1, 0, "R3 word3");
        check_now(12'h000, "R3 third long word 0x000");
        drive(1, 1, 0, "R3 word4");
        check_now(12'h07C, "R3 fourth long word 0x07C");
        for (int i = 0; i < 150; i++) drive(1, 1, 0, "R3 long stream");

        // R6: restart with enable on the same edge
        drive(1, 1, 1, "R6 restart+en");
        check_now(12'hFFF, "R6 restart+en first long word");
        drive(1, 1, 0, "R6 after restart");
        check_now(12'hFFE, "R6 second word after restart");

        // R6: restart alone, then enable
        for (int i = 0; i < 7; i++) drive(1, 1, 0, "R3 stream");
        drive(0, 1, 1, "R6 restart idle");
        drive(0, 1, 0, "R6 idle hold");
        drive(1, 1, 0, "R6 first after idle restart");
        check_now(12'hFFF, "R6 idle restart first word");

        // R7: switch to short while idle
        for (int i = 0; i < 3; i++) drive(1, 1, 0, "R3 stream");
        drive(0, 0, 0, "R7 switch idle");
        drive(1, 0, 0, "R7 first short after idle switch");
        check_now(12'hFF8, "R7 idle switch first word");
        drive(1, 0, 0, "R7 second");
        check_now(12'h3DF, "R7 second short word");

        // R8: period of 511 words
        drive(1, 0, 1, "R8 restart");
        check_now(12'hFF8, "R8 word1");
        for (int i = 0; i < 510; i++) drive(1, 0, 0, "R8 period stream");
        drive(1, 0, 0, "R8 word512");
        check_now(12'hFF8, "R8 word 512 equals word 1");

        drive(0, 0, 0, "R5 final idle");
        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule